// File: doc/BRIEF.md
# Preamble, Sync and Manchester Response Transmitter

This block is the transmit half of a tag-side radio coprocessor. Once the controller has written a response into the output FIFO, it sends a one-cycle transmit command. The block then keys the transmitter on and turns the receiver off. It sends a run of preamble bit periods, then a sync pulse whose shape cannot occur inside Manchester data. Only after the sync pulse has been fully sent does it start Manchester-encoding the buffered bytes onto a single serial line. When the FIFO has run dry, it closes the frame with one quiet bit period, drops the transmit enable and tells the controller that the frame is done.

All serial timing is counted in half-bit periods of `HALF_CYC` clock cycles. The FIFO is read through a first-word-fall-through interface: the byte is valid whenever the FIFO is not empty, and it is removed by a one-cycle read strobe. The next byte is always fetched one bit period before the byte on the line ends, so there is no gap between bytes.

Top module: `manch_burst_tx`

## Requirements
- R1: After reset, `tx_en_o` is 0, `rx_en_o` is 1, and `tx_line_o`, `tx_done_o`, `busy_err_o` and `fifo_rd_o` are all 0.
- R2: A `tx_start_i` sampled while idle sets `tx_en_o` at that clock edge. `rx_en_o` is always the inverse of `tx_en_o`.
- R3: The frame opens with `PRE_BITS` preamble bit periods. Each one is high for its first half and low for its second half.
- R4: The sync pulse follows at once: high for 2 bit periods, then low for 1 bit period.
- R5: Data bytes leave MSB first, in FIFO order. A 1 is sent as low then high, and a 0 as high then low.
- R6: The encoder never drives the line before the last half of the sync pulse has ended.
- R7: `fifo_rd_o` pulses for exactly one cycle, in the last clock of the half-bit before the final bit period of the sync pulse or of a data byte, and only if the FIFO is not empty. Consecutive bytes follow with no gap.
- R8: After the last byte, the line stays low for one bit period. Then `tx_en_o` falls and `tx_done_o` is high for exactly one cycle.
- R9: A `tx_start_i` while transmitting is ignored: the frame is unchanged, and `busy_err_o` is high for one cycle after it.
- R10: If the FIFO is empty at the sync prefetch point, the frame holds the preamble, the sync pulse and the quiet bit period only, and no byte is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start_i | input | 1 | One-cycle transmit command from the controller |
| fifo_empty_i | input | 1 | Output FIFO has no byte |
| fifo_data_i | input | DATA_W | Head byte of the FIFO, valid when not empty |
| fifo_rd_o | output | 1 | Pop strobe for the FIFO head |
| tx_en_o | output | 1 | Transmitter enable toward the air interface |
| rx_en_o | output | 1 | Receiver enable, low while transmitting |
| tx_line_o | output | 1 | Serial line toward the modulator |
| tx_done_o | output | 1 | One-cycle frame-complete pulse |
| busy_err_o | output | 1 | One-cycle flag for a command refused while busy |

## Verification
A wrong half-bit index in the preamble stage shows up on the serial line within one half-bit period. It appears as a preamble or sync level in the wrong place, and it also moves the first FIFO read off its one expected cycle. A fault in the encoder's bit counter or prefetch flag shows up as a wrong level in the first affected byte, a read strobe in the wrong cycle, or a wrong count of popped bytes at the end of the frame. Either kind of fault also moves the fall of `tx_en_o` and the done pulse away from the cycle the frame length predicts. The bench sweeps every byte value through the encoder and checks every cycle of each frame.

// File: rtl/manch_tx_pkg.sv
// Shared types for the Manchester response transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package manch_tx_pkg;

    // Encoder sequencing states
    typedef enum logic [1:0] {
        ENC_IDLE = 2'd0,
        ENC_DATA = 2'd1,
        ENC_TAIL = 2'd2
    } enc_state_e;

endpackage

// File: rtl/mtx_half_timer.sv
// Half-bit timer: emits a one-cycle tick at the last clock of every
// half-bit period while run_i is high. Restarts from zero whenever run_i is low.
// Assumes: HALF_CYC >= 2.
module mtx_half_timer #(
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks inside the current half-bit period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

    // R3: a tick never lasts two cycles, so half-bits never collapse
    p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/mtx_preamble.sv
// Preamble and sync stage: on start_i it sends PRE_BITS bit periods
// (high half, low half), then a sync pulse of 4 high halves and 2 low halves.
// It strobes prefetch_o when the final sync bit period begins, and handoff_o
// when the sync pulse has been fully sent.
// Assumes: tick_i marks the last clock of each half-bit period.
module mtx_preamble #(
    parameter int PRE_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    output logic active_o,
    output logic line_o,
    output logic prefetch_o,
    output logic handoff_o
);
    localparam int NH = 2 * PRE_BITS + 6;
    localparam int IW = $clog2(NH + 1);
    localparam logic [IW-1:0] PRE_END  = IW'(2 * PRE_BITS);
    localparam logic [IW-1:0] HIGH_END = IW'(2 * PRE_BITS + 4);
    localparam logic [IW-1:0] PF_IDX   = IW'(NH - 3);
    localparam logic [IW-1:0] LAST_IDX = IW'(NH - 1);

    logic          act_q;
    logic [IW-1:0] idx_q;

    // Step through the preamble and sync half-bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            idx_q <= '0;
        end else if (start_i) begin
            act_q <= 1'b1;
            idx_q <= '0;
        end else if (act_q && tick_i) begin
            if (idx_q == LAST_IDX) begin
                act_q <= 1'b0;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Decode the line level for the current half-bit
    always_comb begin
        if (!act_q) begin
            line_o = 1'b0;
        end else if (idx_q < PRE_END) begin
            line_o = ~idx_q[0];
        end else begin
            line_o = (idx_q < HIGH_END);
        end
    end

    assign active_o   = act_q;
    assign prefetch_o = act_q && tick_i && (idx_q == PF_IDX);
    assign handoff_o  = act_q && tick_i && (idx_q == LAST_IDX);

    // R3: a preamble starts high on its first half-bit
    p_pre_opens_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (active_o && line_o));

    // R6: handoff closes this stage in the same step
    p_handoff_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        handoff_o |=> !active_o);

endmodule

// File: rtl/mtx_manch_enc.sv
// Manchester encoder: loads the prefetched byte on handoff_i, shifts it out
// MSB first (1 = low then high, 0 = high then low), and fetches the next byte
// one bit period before the current byte ends. If no byte is pending at a
// byte boundary, it sends one low bit period and pulses finish_o.
// Assumes: FIFO is first-word-fall-through, and prefetch_i comes before handoff_i.
module mtx_manch_enc
    import manch_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              prefetch_i,
    input  logic              handoff_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              fifo_rd_o,
    output logic              line_o,
    output logic              busy_o,
    output logic              finish_o
);
    localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);
    localparam logic [BW-1:0] BIT_PF   = BW'(DATA_W - 2);

    enc_state_e        st_q;
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] nxt_q;
    logic              nxt_v_q;
    logic [BW-1:0]     bit_q;
    logic              half_q;
    logic              pf_own;
    logic              byte_end;
    logic              load;

    assign pf_own    = tick_i && (st_q == ENC_DATA) && half_q && (bit_q == BIT_PF);
    assign byte_end  = tick_i && (st_q == ENC_DATA) && half_q && (bit_q == BIT_LAST);
    assign load      = handoff_i || byte_end;
    assign fifo_rd_o = (prefetch_i || pf_own) && !fifo_empty_i;

    // Hold the prefetched byte until the next byte boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q   <= '0;
            nxt_v_q <= 1'b0;
        end else if (fifo_rd_o) begin
            nxt_q   <= fifo_data_i;
            nxt_v_q <= 1'b1;
        end else if (load) begin
            nxt_v_q <= 1'b0;
        end
    end

    // Sequence data half-bits and the closing quiet bit period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ENC_IDLE;
            sh_q   <= '0;
            bit_q  <= '0;
            half_q <= 1'b0;
        end else if (load) begin
            half_q <= 1'b0;
            bit_q  <= '0;
            if (nxt_v_q) begin
                st_q <= ENC_DATA;
                sh_q <= nxt_q;
            end else begin
                st_q <= ENC_TAIL;
            end
        end else if (tick_i) begin
            case (st_q)
                ENC_DATA: begin
                    if (!half_q) begin
                        half_q <= 1'b1;
                    end else begin
                        half_q <= 1'b0;
                        bit_q  <= bit_q + 1'b1;
                        sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
                    end
                end
                ENC_TAIL: begin
                    if (!half_q) begin
                        half_q <= 1'b1;
                    end else begin
                        half_q <= 1'b0;
                        st_q   <= ENC_IDLE;
                    end
                end
                default: half_q <= 1'b0;
            endcase
        end
    end

    // Drive the line from the current bit and half
    always_comb begin
        if (st_q == ENC_DATA) begin
            line_o = half_q ? sh_q[DATA_W-1] : ~sh_q[DATA_W-1];
        end else begin
            line_o = 1'b0;
        end
    end

    assign busy_o   = (st_q != ENC_IDLE);
    assign finish_o = tick_i && (st_q == ENC_TAIL) && half_q;

    // R7: a read strobe is a single cycle
    p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_o |=> !fifo_rd_o);

    // R8: finishing returns the encoder to idle
    p_finish_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> !busy_o);

endmodule

// File: rtl/manch_burst_tx.sv
// Top of the response transmitter: accepts a transmit command while idle,
// keys tx_en_o, runs the preamble/sync stage, then hands off to the
// Manchester encoder. It drops tx_en_o and pulses tx_done_o when the encoder
// finishes. A command while busy is ignored and flagged on busy_err_o.
// Assumes: the controller has filled the FIFO before issuing the command.
module manch_burst_tx #(
    parameter int HALF_CYC = 8,
    parameter int PRE_BITS = 8,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start_i,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              fifo_rd_o,
    output logic              tx_en_o,
    output logic              rx_en_o,
    output logic              tx_line_o,
    output logic              tx_done_o,
    output logic              busy_err_o
);
    logic tx_en_q;
    logic done_q;
    logic berr_q;
    logic accept;
    logic tick;
    logic pre_active;
    logic pre_line;
    logic pre_pf;
    logic pre_handoff;
    logic enc_line;
    logic enc_busy;
    logic enc_finish;

    assign accept = tx_start_i && !tx_en_q;

    // Frame-level enable, done pulse and busy-error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            done_q  <= 1'b0;
            berr_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            berr_q <= tx_start_i && tx_en_q;
            if (accept) begin
                tx_en_q <= 1'b1;
            end else if (enc_finish) begin
                tx_en_q <= 1'b0;
                done_q  <= 1'b1;
            end
        end
    end

    mtx_half_timer #(.HALF_CYC(HALF_CYC)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (tx_en_q),
        .tick_o (tick)
    );

    mtx_preamble #(.PRE_BITS(PRE_BITS)) pre_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (accept),
        .tick_i     (tick),
        .active_o   (pre_active),
        .line_o     (pre_line),
        .prefetch_o (pre_pf),
        .handoff_o  (pre_handoff)
    );

    mtx_manch_enc #(.DATA_W(DATA_W)) enc_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .prefetch_i   (pre_pf),
        .handoff_i    (pre_handoff),
        .fifo_empty_i (fifo_empty_i),
        .fifo_data_i  (fifo_data_i),
        .fifo_rd_o    (fifo_rd_o),
        .line_o       (enc_line),
        .busy_o       (enc_busy),
        .finish_o     (enc_finish)
    );

    assign tx_en_o    = tx_en_q;
    assign rx_en_o    = ~tx_en_q;
    assign tx_line_o  = pre_active ? pre_line : enc_line;
    assign tx_done_o  = done_q;
    assign busy_err_o = berr_q;

    // R2: an idle command keys the transmitter
    p_start_keys_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start_i && !tx_en_o) |=> tx_en_o);

    // R6: preamble stage and encoder never drive at once
    p_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pre_active |-> !enc_busy);

    // R8: done marks the fall of the enable and lasts one cycle
    p_done_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |-> (!tx_en_o && $past(tx_en_o)));
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_o |=> !tx_done_o);

    // R9: a command while busy raises the error flag
    p_busy_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start_i && tx_en_o) |=> busy_err_o);

endmodule

// File: tb/manch_burst_tx_tb.sv
`timescale 1ns/1ps
module manch_burst_tx_tb_top;
    localparam int HC = 4;
    localparam int PB = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          fifo_empty;
    logic [DW-1:0] fifo_data;
    logic          fifo_rd;
    logic          tx_en, rx_en, tx_line, tx_done, busy_err;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] fifo_mem [0:299];
    int fifo_n = 0;
    int pop_cnt = 0;
    int fifo_base = 0;

    always #2.5 clk = ~clk;

    // Bench FIFO model: first-word-fall-through
    always @(posedge clk) if (fifo_rd) pop_cnt <= pop_cnt + 1;
    assign fifo_empty = (pop_cnt - fifo_base) >= fifo_n;
    assign fifo_data  = fifo_empty ? '0 : fifo_mem[pop_cnt - fifo_base];

    manch_burst_tx #(.HALF_CYC(HC), .PRE_BITS(PB), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_start_i(start),
        .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd),
        .tx_en_o(tx_en), .rx_en_o(rx_en), .tx_line_o(tx_line),
        .tx_done_o(tx_done), .busy_err_o(busy_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Expected line level for half-bit k of a frame carrying n bytes
    function automatic int exp_line(int k, int n);
        int j;
        int b;
        if (k < 2*PB) return (k % 2 == 0) ? 1 : 0;           // R3
        if (k < 2*PB + 6) return ((k - 2*PB) < 4) ? 1 : 0;   // R4
        j = k - 2*PB - 6;
        if (j < 16*n) begin                                  // R5
            b = int'(fifo_mem[j/16][DW-1-((j%16)/2)]);
            return (j % 2 == 0) ? 1 - b : b;
        end
        return 0;                                            // R8 quiet bit
    endfunction

    // Expected read strobe in cycle c of a frame carrying n bytes
    function automatic int exp_rd(int c, int n);
        int h;
        int j;
        if ((c + 1) % HC != 0) return 0;
        h = c / HC;
        if (h == 2*PB + 3) return (n >= 1) ? 1 : 0;
        if (h >= 2*PB + 6) begin
            j = h - 2*PB - 6;
            return ((j % 16 == 13) && (j / 16 < n - 1)) ? 1 : 0;
        end
        return 0;
    endfunction

    // Send one frame of n bytes already in fifo_mem; err_at >= 0 injects a busy command
    task automatic run_frame(input int n, input int err_at);
        int total;
        fifo_base = pop_cnt;
        fifo_n = n;
        total = (2*PB + 8 + 16*n) * HC;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        for (int c = 0; c <= total + 1; c++) begin
            @(negedge clk);
            if (c < total) begin
                chk("R2 tx_en", int'(tx_en), 1);
                chk("R2 rx_en", int'(rx_en), 0);
                chk("R8 done low", int'(tx_done), 0);
                if (c % HC == HC/2) chk("R3/R4/R5 line", int'(tx_line), exp_line(c / HC, n));
            end else if (c == total) begin
                chk("R8 tx_en fall", int'(tx_en), 0);
                chk("R8 done pulse", int'(tx_done), 1);
                chk("R2 rx_en back", int'(rx_en), 1);
            end else begin
                chk("R8 done single", int'(tx_done), 0);
            end
            chk("R7 fifo_rd", int'(fifo_rd), exp_rd(c, n));
            chk("R9 busy_err", int'(busy_err), (err_at >= 0 && c == err_at + 1) ? 1 : 0);
            start = (c == err_at) ? 1'b1 : 1'b0;
        end
        chk("R7 R10 bytes read", pop_cnt - fifo_base, n);
        repeat (3) @(negedge clk);
        chk("R2 idle after frame", int'(tx_en), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_en", int'(tx_en), 0);
        chk("R1 rx_en", int'(rx_en), 1);
        chk("R1 line", int'(tx_line), 0);
        chk("R1 done", int'(tx_done), 0);
        chk("R1 busy_err", int'(busy_err), 0);
        chk("R1 fifo_rd", int'(fifo_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 empty FIFO
        run_frame(0, -1);
        // Single byte
        fifo_mem[0] = 8'hA5;
        run_frame(1, -1);
        // R9 busy command mid-data
        fifo_mem[0] = 8'h00; fifo_mem[1] = 8'hFF; fifo_mem[2] = 8'h81; fifo_mem[3] = 8'h3C;
        run_frame(4, 2*PB*HC + 30);
        // R9 busy command during preamble
        run_frame(4, 3);
        // R5 sweep of every byte value
        for (int i = 0; i < 256; i++) fifo_mem[i] = 8'(i);
        run_frame(256, -1);
        // Reversed sweep, back to back
        for (int i = 0; i < 256; i++) fifo_mem[i] = 8'(255 - i);
        run_frame(256, -1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule